// File: doc/BRIEF.md
# Accumulator Status Flag Unit

This block keeps the 16-bit status word of a 32-bit fixed-point accumulator datapath and updates it after every arithmetic operation. Each cycle it may receive one add or subtract descriptor: signed or unsigned, the two 32-bit operands and the raw 32-bit sum the adder produced. From these it derives the carry and signed overflow. It returns the accumulator result, which is clamped when overflow mode is on. It then updates the overflow counter and the V, N, Z and C flags on the next clock edge.

The unit also scales a 32-bit product by the product-shift field of the status word before that product reaches the adder. It widens a 16-bit operand to 32 bits, with sign or zero fill chosen by the sign-extension bit. The status word can be read and written as a whole through a plain register port. The test/control bit is only stored here; other logic writes it.

Top module: `acc_status_unit`

## Requirements
- R1: The status word is laid out as bits 15:10 overflow counter, 9:7 product-shift mode, 6 V, 5 N, 4 Z, 3 C, 2 test/control, 1 overflow mode (OVM), 0 sign-extension mode (SXM), and reads as 0x0000 after reset.
- R2: The product output is the product input shifted left by 1 for mode 000, passed unchanged for 001, and shifted right arithmetically by 1 through 6 (sign bit replicated) for modes 010 through 111.
- R3: After an update, C is 1 when an add carries out of bit 31 or a subtract does not borrow, and 0 otherwise.
- R4: For a signed operation the counter rises by one on a positive overflow and falls by one on a negative overflow.
- R5: For an unsigned operation the counter rises by one on an add that carries and falls by one on a subtract that borrows.
- R6: V is set by any signed overflow and stays set through later updates until a register write clears it.
- R7: After an update, N equals bit 31 of the accumulator result and Z is 1 exactly when that result is zero.
- R8: With OVM at 1, a signed positive overflow gives a result of 0x7FFFFFFF and a signed negative overflow gives 0x80000000. With OVM at 0, or for unsigned operations, the result is the raw sum.
- R9: The 16-bit operand is widened with copies of its bit 15 when SXM is 1, and with zeros when SXM is 0.
- R10: A register write in the same cycle as an update loads the written word and drops the update. With neither one, the word holds. The test/control bit changes only on writes.
- R11: The overflow counter wraps modulo 64 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle; update the status word |
| op_sub | input | 1 | 1 = subtract (a - b), 0 = add (a + b) |
| op_signed | input | 1 | 1 = signed operation, 0 = unsigned |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sum | input | 32 | Raw 32-bit adder output for the operation |
| prod_in | input | 32 | Multiplier product before scaling |
| ext_in | input | 16 | Short operand to widen |
| reg_wr_en | input | 1 | Write the whole status word |
| reg_wdata | input | 16 | Status word to write |
| acc_result | output | 32 | Accumulator result, clamped when enabled |
| prod_out | output | 32 | Scaled product |
| ext_out | output | 32 | Widened short operand |
| reg_rdata | output | 16 | Current status word |

## Verification
The bench drives every shift code at the extreme products 0x80000000 and 0x7FFFFFFF. A wrong fill bit or an off-by-one shift amount would turn negative products positive, or halve them one step too few. It also drives operations that saturate and count on the same edge. A design that clamps but skips the counter, or counts the clamped value instead of the true overflow, would leave the counter or N wrong. Further cases cover counter wrap at 63 and 0, subtraction of 0x80000000, carry against borrow on unsigned subtracts, and a write that lands together with an update. In these cases a broken design would wrap wrongly, invert C, or let the update overwrite the written word.

// File: rtl/acc_status_pkg.sv
// Shared layout of the accumulator status word.
// Assumes a 16-bit word: 6-bit counter, 3-bit shift mode, seven single bits.
package acc_status_pkg;
    localparam int OVC_W  = 6;
    localparam int PM_W   = 3;
    localparam int STAT_W = OVC_W + PM_W + 7;

    typedef struct packed {
        logic [OVC_W-1:0] ovc;   // overflow counter
        logic [PM_W-1:0]  pm;    // product-shift mode
        logic             v;     // sticky overflow
        logic             n;     // negative
        logic             z;     // zero
        logic             c;     // carry / not-borrow
        logic             tc;    // test/control, stored only
        logic             ovm;   // saturate on overflow
        logic             sxm;   // sign-extend short operands
    } status_t;
endpackage

// File: rtl/acc_prod_scaler.sv
// Scales the product by the shift mode: code 0 shifts left one place,
// code 1 passes the product, codes 2 and up shift right arithmetically
// by (code - 1). Purely combinational.
module acc_prod_scaler #(
    parameter int DATA_W = 32,
    parameter int PM_W   = 3
) (
    input  logic [DATA_W-1:0] prod_in,
    input  logic [PM_W-1:0]   pm,
    output logic [DATA_W-1:0] prod_out
);
    localparam int N_MODES = 1 << PM_W;

    logic [DATA_W-1:0] opt [N_MODES];

    // One candidate per shift code; the mode picks one of them.
    for (genvar k = 0; k < N_MODES; k++) begin : g_mode
        if (k == 0) begin : g_left
            assign opt[k] = {prod_in[DATA_W-2:0], 1'b0};
        end else if (k == 1) begin : g_pass
            assign opt[k] = prod_in;
        end else begin : g_right
            assign opt[k] = $unsigned($signed(prod_in) >>> (k - 1));
        end
    end

    assign prod_out = opt[pm];
endmodule

// File: rtl/acc_operand_ext.sv
// Widens a short operand to the datapath width, filling with its sign
// bit when sxm is set and with zeros otherwise. Assumes OUT_W > IN_W.
module acc_operand_ext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  op_in,
    input  logic             sxm,
    output logic [OUT_W-1:0] op_out
);
    localparam int PAD_W = OUT_W - IN_W;

    logic fill;

    // Fill bit is the operand sign only in sign-extension mode.
    assign fill   = sxm & op_in[IN_W-1];
    assign op_out = {{PAD_W{fill}}, op_in};
endmodule

// File: rtl/acc_add_judge.sv
// Derives carry and signed overflow of an add or subtract from the
// operand and sum sign bits, and clamps the result when overflow mode is
// on. Assumes op_sum is a+b or a-b modulo 2^DATA_W.
module acc_add_judge #(
    parameter int DATA_W = 32
) (
    input  logic              op_sub,
    input  logic              op_signed,
    input  logic              ovm,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_sum,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              pos_ovf,
    output logic              neg_ovf
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic a_msb, b_eff, s_msb, ovf;

    // Subtract is a + ~b + 1, so the effective second sign is inverted.
    assign a_msb = op_a[DATA_W-1];
    assign b_eff = op_b[DATA_W-1] ^ op_sub;
    assign s_msb = op_sum[DATA_W-1];

    // Carry out of the top bit from the majority of a, b and carry-in.
    assign carry = (a_msb & b_eff) | ((a_msb | b_eff) & ~s_msb);

    // Signed overflow: like-signed inputs giving an unlike-signed sum.
    assign ovf     = op_signed & (a_msb == b_eff) & (s_msb != a_msb);
    assign pos_ovf = ovf & ~a_msb;
    assign neg_ovf = ovf & a_msb;

    // Clamp towards the overflow direction when saturation is enabled.
    always_comb begin
        result = op_sum;
        if (ovm && pos_ovf) result = MAX_POS;
        else if (ovm && neg_ovf) result = MAX_NEG;
    end
endmodule

// File: rtl/acc_status_reg.sv
// Holds the status word. A write loads it whole and takes priority;
// otherwise an update refreshes the flags and steps the counter.
// Assumes pos_ovf/neg_ovf are only raised for signed operations.
module acc_status_reg
    import acc_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic              upd,
    input  logic              op_signed,
    input  logic              op_sub,
    input  logic              carry,
    input  logic              pos_ovf,
    input  logic              neg_ovf,
    input  logic              res_neg,
    input  logic              res_zero,
    output status_t           status
);
    status_t          st_q;
    logic             step_up, step_dn;
    logic [OVC_W-1:0] ovc_next;

    // Counter direction for signed (overflow) and unsigned (carry/borrow).
    always_comb begin
        if (op_signed) begin
            step_up = pos_ovf;
            step_dn = neg_ovf;
        end else begin
            step_up = ~op_sub & carry;
            step_dn = op_sub & ~carry;
        end
    end

    // Next counter value, wrapping modulo 2^OVC_W.
    always_comb begin
        ovc_next = st_q.ovc;
        if (step_up)      ovc_next = st_q.ovc + 1'b1;
        else if (step_dn) ovc_next = st_q.ovc - 1'b1;
    end

    // Status register: reset, write, or flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (wr_en) begin
            st_q <= status_t'(wdata);
        end else if (upd) begin
            st_q.ovc <= ovc_next;
            st_q.v   <= st_q.v | pos_ovf | neg_ovf;
            st_q.n   <= res_neg;
            st_q.z   <= res_zero;
            st_q.c   <= carry;
        end
    end

    assign status = st_q;

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status == status_t'($past(wdata))));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd) |=> $stable(status));

    p_tc_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status.tc));

    p_v_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status.v && !wr_en) |=> status.v);

    p_ovc_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && op_signed && pos_ovf)
        |=> (status.ovc == OVC_W'($past(status.ovc) + 1'b1)));

    p_ovc_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && !op_signed && op_sub && !carry)
        |=> (status.ovc == OVC_W'($past(status.ovc) - 1'b1)));

    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en) |=> (status.c == $past(carry)));
endmodule

// File: rtl/acc_status_unit.sv
// Top of the accumulator status unit: ties the product scaler, operand
// widener, add/sub judge and status register together. Results are
// combinational; the status word changes on the clock edge after op_valid.
module acc_status_unit
    import acc_status_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sub,
    input  logic              op_signed,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_sum,
    input  logic [DATA_W-1:0] prod_in,
    input  logic [EXT_W-1:0]  ext_in,
    input  logic              reg_wr_en,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] acc_result,
    output logic [DATA_W-1:0] prod_out,
    output logic [DATA_W-1:0] ext_out,
    output logic [STAT_W-1:0] reg_rdata
);
    localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    status_t st;
    logic    carry, pos_ovf, neg_ovf;

    acc_prod_scaler #(.DATA_W(DATA_W), .PM_W(PM_W)) u_scaler (
        .prod_in  (prod_in),
        .pm       (st.pm),
        .prod_out (prod_out)
    );

    acc_operand_ext #(.IN_W(EXT_W), .OUT_W(DATA_W)) u_ext (
        .op_in  (ext_in),
        .sxm    (st.sxm),
        .op_out (ext_out)
    );

    acc_add_judge #(.DATA_W(DATA_W)) u_judge (
        .op_sub    (op_sub),
        .op_signed (op_signed),
        .ovm       (st.ovm),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sum    (op_sum),
        .result    (acc_result),
        .carry     (carry),
        .pos_ovf   (pos_ovf),
        .neg_ovf   (neg_ovf)
    );

    acc_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .upd       (op_valid),
        .op_signed (op_signed),
        .op_sub    (op_sub),
        .carry     (carry),
        .pos_ovf   (pos_ovf),
        .neg_ovf   (neg_ovf),
        .res_neg   (acc_result[DATA_W-1]),
        .res_zero  (acc_result == '0),
        .status    (st)
    );

    assign reg_rdata = STAT_W'(st);

    p_sat_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && st.ovm && pos_ovf) |-> (acc_result == SAT_POS));

    p_sat_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && st.ovm && neg_ovf) |-> (acc_result == SAT_NEG));

    p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !reg_wr_en)
        |=> (st.n == $past(acc_result[DATA_W-1]))
            && (st.z == ($past(acc_result) == '0)));
endmodule

// File: tb/acc_status_unit_tb.sv
// Self-checking bench: a behavioural reference model of the status word
// is stepped alongside the design and compared every cycle.
module acc_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_sub, op_signed;
    logic [31:0] op_a, op_b, op_sum, prod_in;
    logic [15:0] ext_in;
    logic        reg_wr_en;
    logic [15:0] reg_wdata;
    logic [31:0] acc_result, prod_out, ext_out;
    logic [15:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_st;   // model status word, layout per R1

    always #4 clk = ~clk;   // 125 MHz

    acc_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .op_signed(op_signed), .op_a(op_a), .op_b(op_b), .op_sum(op_sum),
        .prod_in(prod_in), .ext_in(ext_in), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .acc_result(acc_result), .prod_out(prod_out),
        .ext_out(ext_out), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // R2 model: shift one place at a time with sign replication.
    function automatic logic [31:0] ref_prod(input logic [31:0] p, input int mode);
        logic [31:0] r = p;
        if (mode == 0) return {p[30:0], 1'b0};
        for (int i = 1; i < mode; i++) r = {r[31], r[31:1]};
        return r;
    endfunction

    // Signed overflow direction: +1 positive, -1 negative, 0 none.
    function automatic int ovf_dir(input logic sub, input logic [31:0] a, input logic [31:0] b);
        longint s = sub ? (longint'($signed(a)) - longint'($signed(b)))
                        : (longint'($signed(a)) + longint'($signed(b)));
        if (s > 64'sd2147483647) return 1;
        if (s < -64'sd2147483648) return -1;
        return 0;
    endfunction

    function automatic logic ref_carry(input logic sub, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w = {1'b0, a} + {1'b0, b};
        return sub ? (a >= b) : w[32];
    endfunction

    function automatic logic [31:0] ref_result(input logic sub, input logic sgn,
                                               input logic [31:0] a, input logic [31:0] b);
        int d = sgn ? ovf_dir(sub, a, b) : 0;
        if (m_st[1] && d == 1)  return 32'h7FFF_FFFF;
        if (m_st[1] && d == -1) return 32'h8000_0000;
        return sub ? a - b : a + b;
    endfunction

    // One cycle: drive at negedge, check outputs, then status after the edge.
    task automatic cyc(input string tag, input logic valid, input logic sub, input logic sgn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic wr, input logic [15:0] wd,
                       input logic [31:0] prod, input logic [15:0] ext);
        logic [31:0] res;
        int          d;
        logic        cy;
        int          cnt;
        @(negedge clk);
        op_valid = valid; op_sub = sub; op_signed = sgn; op_a = a; op_b = b;
        op_sum = sub ? a - b : a + b;
        reg_wr_en = wr; reg_wdata = wd; prod_in = prod; ext_in = ext;
        #1;
        res = ref_result(sub, sgn, a, b);
        check({tag, " R8 result"}, acc_result, res);
        check({tag, " R2 product"}, prod_out, ref_prod(prod, int'(m_st[9:7])));
        check({tag, " R9 widen"}, ext_out,
              m_st[0] ? {{16{ext[15]}}, ext} : {16'h0, ext});
        @(posedge clk);
        #1;
        if (wr) begin
            m_st = wd;
        end else if (valid) begin
            d   = sgn ? ovf_dir(sub, a, b) : 0;
            cy  = ref_carry(sub, a, b);
            cnt = int'(m_st[15:10]);
            if (sgn) cnt = cnt + d;
            else if (!sub && cy) cnt = cnt + 1;
            else if (sub && !cy) cnt = cnt - 1;
            m_st[15:10] = 6'((cnt + 64) % 64);
            if (d != 0) m_st[6] = 1'b1;
            m_st[5] = res[31];
            m_st[4] = (res == 32'h0);
            m_st[3] = cy;
        end
        check({tag, " R1 R3 R4 R5 R6 R7 R10 R11 status"}, {16'h0, reg_rdata}, {16'h0, m_st});
    endtask

    task automatic idle(input string tag, input logic [31:0] prod, input logic [15:0] ext);
        cyc(tag, 0, 0, 0, 0, 0, 0, 16'h0, prod, ext);
    endtask

    task automatic wr(input string tag, input logic [15:0] wd);
        cyc(tag, 0, 0, 0, 0, 0, 1, wd, 0, 0);
    endtask

    task automatic op(input string tag, input logic sub, input logic sgn,
                      input logic [31:0] a, input logic [31:0] b);
        cyc(tag, 1, sub, sgn, a, b, 0, 16'h0, 32'h1234_5678, 16'h8001);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] extremes [4] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF};
        rst_n = 1'b0; op_valid = 0; op_sub = 0; op_signed = 0; op_a = 0; op_b = 0;
        op_sum = 0; prod_in = 0; ext_in = 0; reg_wr_en = 0; reg_wdata = 0;
        m_st = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", {16'h0, reg_rdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every shift code at the extreme products
        for (int m = 0; m < 8; m++) begin
            wr("R2 set mode", 16'(m << 7));
            foreach (extremes[i]) idle("R2 shift", extremes[i], 16'h7FFF);
        end

        // R8 with R4: saturate and count on the same operation
        wr("R8 ovm on", 16'h0002);
        op("R8 R4 pos sat", 0, 1, 32'h7FFF_FFFF, 32'h1);
        op("R8 R4 neg sat", 1, 1, 32'h8000_0000, 32'h1);
        op("R8 R4 sub min", 1, 1, 32'h0, 32'h8000_0000);
        wr("R8 ovm off", 16'h0000);
        op("R8 R7 wrap", 0, 1, 32'h7FFF_FFFF, 32'h1);
        op("R6 V sticky", 0, 1, 32'h5, 32'h3);
        wr("R6 clear", 16'h0000);

        // R3 R5: unsigned carry and borrow
        op("R5 R7 carry zero", 0, 0, 32'hFFFF_FFFF, 32'h1);
        op("R5 R3 borrow", 1, 0, 32'h0, 32'h1);
        op("R3 no borrow", 1, 0, 32'h9, 32'h9);
        op("R3 no carry", 0, 0, 32'h1, 32'h2);

        // R11: counter wrap both ways
        wr("R11 set 63", 16'hFC00);
        op("R11 up wrap", 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        wr("R11 set 0", 16'h0000);
        op("R11 down wrap", 0, 1, 32'h8000_0000, 32'h8000_0000);

        // R10: write beats update, TC held, idle holds
        cyc("R10 write wins", 1, 0, 1, 32'h7FFF_FFFF, 32'h1, 1, 16'h0044, 0, 0);
        op("R10 tc kept", 0, 0, 32'hFFFF_FFFF, 32'h2);
        idle("R10 idle", 0, 0);

        // R9: widening in both modes
        wr("R9 sxm on", 16'h0001);
        idle("R9 neg", 0, 16'h8000);
        idle("R9 pos", 0, 16'h7FFF);
        wr("R9 sxm off", 16'h0000);
        idle("R9 zero fill", 0, 16'hFFFF);

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 0)
                wr("R10 mixed write", 16'($urandom));
            else
                cyc("R4 R5 mixed", 1'($urandom), 1'($urandom), 1'($urandom),
                    (i % 5 == 0) ? 32'h7FFF_FFFF : $urandom,
                    (i % 7 == 0) ? 32'h8000_0000 : $urandom,
                    0, 16'h0, $urandom, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule